// File: doc/BRIEF.md
# MESI Snooping Coherence Line Controller

This block keeps the coherence state of every line in one private write-back cache that sits on a shared snooping bus. It holds a small direct-mapped array where each entry carries a state (Modified, Exclusive, Shared or Invalid), an address tag and a one-word line payload. It accepts processor reads and writes and answers them from the array when it can. When it cannot, it requests the bus and issues a read, a read-for-ownership, an upgrade or a write-back.

At the same time it watches the transactions of the other agents on the bus and moves its own copies to follow them. When it holds a valid copy of a line that another agent reads, it supplies the word by cache-to-cache transfer. All read misses look the same on the bus. The requester picks Exclusive when memory alone answered, and Shared when any cache answered. Main memory captures every word that a cache supplies, so memory is consistent after each transfer.

Both processor ports use valid/ready handshakes. A request is taken when `req_valid` and `req_ready` are both high, and only one request is outstanding at a time. A response stays on `resp_valid`/`resp_rdata` without change until `resp_ready` is seen high. The bus side uses plain control pins. The bus is granted to one agent per cycle, and a granted read or read-for-ownership is answered on `fill_valid` in the following cycle. Snoop results are combinational in the cycle the transaction is broadcast.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every entry is Invalid. `req_ready` is 1 and `resp_valid` and `bus_req` are 0, so the first access to any address misses.
- R2: A read miss issues bus command 0 (read). The line is installed as Exclusive when `fill_shared` is 0 and as Shared when it is 1. The fill data is returned.
- R3: A snooped read (command 0) that hits a valid copy raises `snoop_hit` and `supply_valid` with the line's word on `supply_data`, including a clean Exclusive copy. The copy then becomes Shared.
- R4: A write hit on an Exclusive or Modified line completes with no bus transaction and leaves the line Modified.
- R5: A write hit on a Shared line issues bus command 2 (upgrade) and becomes Modified once granted.
- R6: A write miss issues bus command 1 (read-for-ownership) and installs the line as Modified with the written word.
- R7: A snooped read-for-ownership or upgrade moves a valid copy to Invalid. Only a Modified copy supplies data on a read-for-ownership, and nothing supplies on an upgrade.
- R8: A miss whose victim entry is Modified first issues bus command 3 (write-back), carrying the victim's address and word on `bus_addr`/`bus_wdata`. An Exclusive or Shared victim is dropped with no bus transaction.
- R9: A snoop to the same index as the pending request stalls a local hit in that cycle. The request is then decided again against the updated state.
- R10: Every read returns the most recently written word. No line is Modified or Exclusive in one cache while it is valid in another.
- R11: A response is held stable until `resp_ready`. No new request is taken while one is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Processor takes the response |
| resp_rdata | output | DATA_W | Read word (write word for writes) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction happens this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| fill_valid | input | 1 | Fill for own read or read-for-ownership |
| fill_shared | input | 1 | Fill came from another cache |
| fill_data | input | DATA_W | Fill word |
| snoop_valid | input | 1 | Another agent's transaction this cycle |
| snoop_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_hit | output | 1 | Shared-line response: valid copy present |
| supply_valid | output | 1 | Supplying the line word |
| supply_data | output | DATA_W | Supplied word |

## Verification
A wrong entry state shows up at the ports within one request. A line wrongly left Exclusive or Modified skips an upgrade, and a line wrongly Shared issues an extra one. Either way the command sequence of the next write differs from what a reference state model predicts. A stale copy that survives a snoop is exposed by the next read on the other cache, which returns an old word. Two caches are run together through sweeps over all indices and several tags, plus a race in which a local write hit meets a snooped read to the same line in the same cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef logic [1:0] line_st_t;
  localparam line_st_t ST_I = 2'd0;
  localparam line_st_t ST_S = 2'd1;
  localparam line_st_t ST_E = 2'd2;
  localparam line_st_t ST_M = 2'd3;

  typedef logic [1:0] bus_op_t;
  localparam bus_op_t OP_RD  = 2'd0;
  localparam bus_op_t OP_RFO = 2'd1;
  localparam bus_op_t OP_UPG = 2'd2;
  localparam bus_op_t OP_WB  = 2'd3;
endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int INDEX_W = 2,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] p_idx,
  output line_st_t           p_st,
  output logic [TAG_W-1:0]   p_tag,
  output logic [DATA_W-1:0]  p_data,
  input  logic [INDEX_W-1:0] s_idx,
  output line_st_t           s_st,
  output logic [TAG_W-1:0]   s_tag,
  output logic [DATA_W-1:0]  s_data,
  input  logic               p_we,
  input  logic [INDEX_W-1:0] p_widx,
  input  line_st_t           p_wst,
  input  logic [TAG_W-1:0]   p_wtag,
  input  logic [DATA_W-1:0]  p_wdata,
  input  logic               s_we,
  input  logic [INDEX_W-1:0] s_widx,
  input  line_st_t           s_wst
);
  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (s_we && s_widx == INDEX_W'(i)) begin
        st_q[i] <= s_wst;
      end else if (p_we && p_widx == INDEX_W'(i)) begin
        st_q[i]   <= p_wst;
        tag_q[i]  <= p_wtag;
        data_q[i] <= p_wdata;
      end
    end
  end

  assign p_st   = st_q[p_idx];
  assign p_tag  = tag_q[p_idx];
  assign p_data = data_q[p_idx];
  assign s_st   = st_q[s_idx];
  assign s_tag  = tag_q[s_idx];
  assign s_data = data_q[s_idx];

  // R9: processor and snoop never update the same entry in one cycle
  p_no_dual_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_we && p_we && s_widx == p_widx));

  // R7: a snoop update lands in the entry it addressed
  p_snoop_applied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |=> st_q[$past(s_widx)] == $past(s_wst));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snoop_valid,
  input  bus_op_t            snoop_cmd,
  input  logic [ADDR_W-1:0]  snoop_addr,
  output logic [INDEX_W-1:0] s_idx,
  input  line_st_t           s_st,
  input  logic [TAG_W-1:0]   s_tag,
  input  logic [DATA_W-1:0]  s_data,
  output logic               snoop_hit,
  output logic               supply_valid,
  output logic [DATA_W-1:0]  supply_data,
  output logic               s_we,
  output line_st_t           s_wst
);
  logic copy_here;

  assign s_idx     = snoop_addr[INDEX_W-1:0];
  assign copy_here = snoop_valid && (s_st != ST_I) &&
                     (s_tag == snoop_addr[ADDR_W-1:INDEX_W]);

  always_comb begin
    snoop_hit    = 1'b0;
    supply_valid = 1'b0;
    s_we         = 1'b0;
    s_wst        = ST_I;
    if (copy_here) begin
      unique case (snoop_cmd)
        OP_RD: begin
          snoop_hit    = 1'b1;
          supply_valid = 1'b1;
          s_we         = 1'b1;
          s_wst        = ST_S;
        end
        OP_RFO: begin
          snoop_hit    = 1'b1;
          supply_valid = (s_st == ST_M);
          s_we         = 1'b1;
        end
        OP_UPG: begin
          snoop_hit = 1'b1;
          s_we      = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign supply_data = s_data;

  // R3: data is only supplied from a valid copy
  p_supply_has_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_valid |-> snoop_hit);

  // R7: an upgrade is never answered with data
  p_upgrade_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd == OP_UPG) |-> !supply_valid);
endmodule

// File: rtl/mesi_proc_ctrl.sv
module mesi_proc_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [DATA_W-1:0]  resp_rdata,
  output logic               bus_req,
  input  logic               bus_gnt,
  output bus_op_t            bus_cmd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               fill_valid,
  input  logic               fill_shared,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic               snoop_valid,
  input  logic [ADDR_W-1:0]  snoop_addr,
  output logic [INDEX_W-1:0] p_idx,
  input  line_st_t           p_st,
  input  logic [TAG_W-1:0]   p_tag,
  input  logic [DATA_W-1:0]  p_data,
  output logic               p_we,
  output line_st_t           p_wst,
  output logic [TAG_W-1:0]   p_wtag,
  output logic [DATA_W-1:0]  p_wdata
);
  typedef enum logic [1:0] {P_IDLE, P_LOOK, P_FILL, P_RESP} phase_t;

  phase_t              ph_q;
  logic [ADDR_W-1:0]   a_q;
  logic                w_q;
  logic [DATA_W-1:0]   d_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [TAG_W-1:0]    my_tag;
  logic                hit, local_ok, snp_same, look;

  assign p_idx    = a_q[INDEX_W-1:0];
  assign my_tag   = a_q[ADDR_W-1:INDEX_W];
  assign look     = (ph_q == P_LOOK);
  assign hit      = (p_st != ST_I) && (p_tag == my_tag);
  assign snp_same = snoop_valid && (snoop_addr[INDEX_W-1:0] == p_idx);

  // Decision is recomputed every cycle from the live entry state
  always_comb begin
    bus_req   = 1'b0;
    bus_cmd   = OP_RD;
    bus_addr  = a_q;
    bus_wdata = p_data;
    local_ok  = 1'b0;
    if (look) begin
      if (hit) begin
        if (w_q && p_st == ST_S) begin
          bus_req = 1'b1;
          bus_cmd = OP_UPG;
        end else begin
          local_ok = !snp_same;
        end
      end else if (p_st == ST_M) begin
        bus_req  = 1'b1;
        bus_cmd  = OP_WB;
        bus_addr = {p_tag, p_idx};
      end else begin
        bus_req = 1'b1;
        bus_cmd = w_q ? OP_RFO : OP_RD;
      end
    end
  end

  always_comb begin
    p_we    = 1'b0;
    p_wst   = ST_M;
    p_wtag  = my_tag;
    p_wdata = d_q;
    if (local_ok && w_q) begin
      p_we = 1'b1;
    end else if (look && bus_req && bus_gnt && bus_cmd == OP_UPG) begin
      p_we = 1'b1;
    end else if (look && bus_req && bus_gnt && bus_cmd == OP_WB) begin
      p_we    = 1'b1;
      p_wst   = ST_I;
      p_wtag  = p_tag;
      p_wdata = p_data;
    end else if (ph_q == P_FILL && fill_valid) begin
      p_we    = 1'b1;
      p_wst   = w_q ? ST_M : (fill_shared ? ST_S : ST_E);
      p_wdata = w_q ? d_q : fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= P_IDLE;
      a_q     <= '0;
      w_q     <= 1'b0;
      d_q     <= '0;
      rdata_q <= '0;
    end else begin
      unique case (ph_q)
        P_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          w_q  <= req_write;
          d_q  <= req_wdata;
          ph_q <= P_LOOK;
        end
        P_LOOK: begin
          if (local_ok) begin
            rdata_q <= w_q ? d_q : p_data;
            ph_q    <= P_RESP;
          end else if (bus_req && bus_gnt) begin
            if (bus_cmd == OP_UPG) begin
              rdata_q <= d_q;
              ph_q    <= P_RESP;
            end else if (bus_cmd != OP_WB) begin
              ph_q <= P_FILL;
            end
          end
        end
        P_FILL: if (fill_valid) begin
          rdata_q <= w_q ? d_q : fill_data;
          ph_q    <= P_RESP;
        end
        P_RESP: if (resp_ready) ph_q <= P_IDLE;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assign req_ready  = (ph_q == P_IDLE);
  assign resp_valid = (ph_q == P_RESP);
  assign resp_rdata = rdata_q;

  // R2: a fill phase is only entered after a granted bus transaction
  p_fill_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_q == P_FILL) |-> $past(bus_req && bus_gnt));

  // R5: an upgrade is only requested from a Shared copy of the line
  p_upgrade_from_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == OP_UPG) |-> (p_st == ST_S && p_tag == my_tag));

  // R8: a write-back only evicts a dirty line of another tag
  p_wb_dirty_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == OP_WB) |-> (p_st == ST_M && p_tag != my_tag));

  // R9: a same-index snoop holds the request in lookup
  p_snoop_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (look && snp_same && !bus_gnt) |=> (ph_q == P_LOOK));

  // R11: response held until taken
  p_resp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)));

  // R11: one request in flight
  p_single_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              fill_valid,
  input  logic              fill_shared,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_hit,
  output logic              supply_valid,
  output logic [DATA_W-1:0] supply_data
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] p_idx, s_idx;
  line_st_t           p_st, s_st, p_wst, s_wst;
  logic [TAG_W-1:0]   p_tag, s_tag, p_wtag;
  logic [DATA_W-1:0]  p_data, s_data, p_wdata;
  logic               p_we, s_we;

  mesi_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .p_idx(p_idx), .p_st(p_st), .p_tag(p_tag), .p_data(p_data),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
    .p_we(p_we), .p_widx(p_idx), .p_wst(p_wst), .p_wtag(p_wtag), .p_wdata(p_wdata),
    .s_we(s_we), .s_widx(s_idx), .s_wst(s_wst)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
    .snoop_hit(snoop_hit), .supply_valid(supply_valid), .supply_data(supply_data),
    .s_we(s_we), .s_wst(s_wst)
  );

  mesi_proc_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_proc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fill_valid(fill_valid), .fill_shared(fill_shared), .fill_data(fill_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .p_idx(p_idx), .p_st(p_st), .p_tag(p_tag), .p_data(p_data),
    .p_we(p_we), .p_wst(p_wst), .p_wtag(p_wtag), .p_wdata(p_wdata)
  );
endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_RD = 2'd0, C_RFO = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2, S_M = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] req_valid, req_ready, req_write, resp_valid, resp_ready;
  logic [1:0] bus_req, gnt, fill_valid, snoop_valid, snoop_hit, supply_valid;
  logic [7:0]  req_addr [2];
  logic [15:0] req_wdata [2];
  logic [15:0] resp_rdata [2];
  logic [1:0]  bus_cmd [2];
  logic [7:0]  bus_addr [2];
  logic [15:0] bus_wdata [2];
  logic [1:0]  snoop_cmd [2];
  logic [7:0]  snoop_addr [2];
  logic [15:0] supply_data [2];
  logic        fill_shared;
  logic [15:0] fill_data;

  for (genvar gi = 0; gi < 2; gi++) begin : g_c
    mesi_line_ctrl i_mesi_line_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[gi]), .req_ready(req_ready[gi]), .req_write(req_write[gi]),
      .req_addr(req_addr[gi]), .req_wdata(req_wdata[gi]),
      .resp_valid(resp_valid[gi]), .resp_ready(resp_ready[gi]), .resp_rdata(resp_rdata[gi]),
      .bus_req(bus_req[gi]), .bus_gnt(gnt[gi]), .bus_cmd(bus_cmd[gi]),
      .bus_addr(bus_addr[gi]), .bus_wdata(bus_wdata[gi]),
      .fill_valid(fill_valid[gi]), .fill_shared(fill_shared), .fill_data(fill_data),
      .snoop_valid(snoop_valid[gi]), .snoop_cmd(snoop_cmd[gi]), .snoop_addr(snoop_addr[gi]),
      .snoop_hit(snoop_hit[gi]), .supply_valid(supply_valid[gi]), .supply_data(supply_data[gi])
    );
  end

  // Bus model: one transaction per cycle, fill one cycle after a read-type grant
  logic        prio, fill_pend, fill_who, ow;
  logic [15:0] mem [256];

  always_comb begin
    gnt = 2'b00;
    if (!fill_pend) begin
      if (bus_req[prio]) gnt[prio] = 1'b1;
      else if (bus_req[~prio]) gnt[~prio] = 1'b1;
    end
    ow = gnt[1];
    for (int c = 0; c < 2; c++) begin
      snoop_valid[c] = (|gnt) && !gnt[c];
      snoop_cmd[c]   = bus_cmd[ow];
      snoop_addr[c]  = bus_addr[ow];
    end
    fill_valid[0] = fill_pend && !fill_who;
    fill_valid[1] = fill_pend && fill_who;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      prio <= 1'b0; fill_pend <= 1'b0; fill_who <= 1'b0;
      fill_shared <= 1'b0; fill_data <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 3 + 256);
    end else begin
      fill_pend <= 1'b0;
      if (|gnt) begin
        prio <= ~ow;
        if (bus_cmd[ow] == C_WB) mem[bus_addr[ow]] <= bus_wdata[ow];
        if (supply_valid[~ow]) mem[bus_addr[ow]] <= supply_data[~ow];
        if (bus_cmd[ow] == C_RD || bus_cmd[ow] == C_RFO) begin
          fill_pend   <= 1'b1;
          fill_who    <= ow;
          fill_shared <= supply_valid[~ow];
          fill_data   <= supply_valid[~ow] ? supply_data[~ow] : mem[bus_addr[ow]];
        end
      end
    end
  end

  // Per-cache command monitor
  int          rec_n [2];
  logic [1:0]  rec_c0 [2], rec_c1 [2];
  logic        rec_sup [2];
  logic [15:0] rec_sd [2];
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (gnt[c]) begin
        if (rec_n[c] == 0) rec_c0[c] = bus_cmd[c]; else rec_c1[c] = bus_cmd[c];
        rec_n[c]++;
        if (bus_cmd[c] != C_WB) begin
          rec_sup[c] = supply_valid[1-c];
          rec_sd[c]  = supply_data[1-c];
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Reference model of states and values
  logic [1:0]  ms [2][4];
  logic [5:0]  mt [2][4];
  logic [15:0] shadow [256];

  task automatic raw_op(input int c, input bit w, input logic [7:0] a,
                        input logic [15:0] d, input bit hold, output logic [15:0] rd);
    int n = 0;
    rec_n[c] = 0;
    @(negedge clk);
    req_valid[c] = 1'b1; req_write[c] = w; req_addr[c] = a; req_wdata[c] = d;
    resp_ready[c] = !hold;
    @(negedge clk);
    req_valid[c] = 1'b0;
    while (!resp_valid[c] && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk(0, "R11", "response timeout", 32'(n), 0);
    rd = resp_rdata[c];
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(resp_valid[c] && resp_rdata[c] == rd, "R11", "held response",
            {15'd0, resp_valid[c], resp_rdata[c]}, {16'd1, rd});
      end
      resp_ready[c] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic do_op(input int c, input bit w, input logic [7:0] a,
                       input logic [15:0] d, input bit hold);
    int o = 1 - c;
    logic [1:0] ix = a[1:0];
    logic [5:0] tg = a[7:2];
    bit hit  = ms[c][ix] != S_I && mt[c][ix] == tg;
    bit oth  = ms[o][ix] != S_I && mt[o][ix] == tg;
    bit othm = oth && ms[o][ix] == S_M;
    int en = 0;
    logic [1:0] e0 = C_RD, e1 = C_RD, last;
    string rq;
    logic [15:0] rd;
    bit es;
    if (hit) begin
      if (w && ms[c][ix] == S_S) begin en = 1; e0 = C_UPG; rq = "R5"; end
      else rq = w ? "R4" : "R10";
    end else if (ms[c][ix] == S_M) begin
      en = 2; e0 = C_WB; e1 = w ? C_RFO : C_RD; rq = "R8";
    end else begin
      en = 1; e0 = w ? C_RFO : C_RD; rq = w ? "R6" : "R2";
    end
    raw_op(c, w, a, d, hold, rd);
    chk(rec_n[c] == en && (en < 1 || rec_c0[c] == e0) && (en < 2 || rec_c1[c] == e1),
        rq, "bus commands", {16'(rec_n[c]), 4'd0, 4'(rec_c0[c]), 4'd0, 4'(rec_c1[c])},
        {16'(en), 4'd0, 4'(e0), 4'd0, 4'(e1)});
    if (!w) chk(rd == shadow[a], "R10", "read value", rd, shadow[a]);
    last = (en == 2) ? e1 : e0;
    if (en > 0 && last != C_WB) begin
      es = (last == C_RD) ? oth : ((last == C_RFO) ? othm : 1'b0);
      chk(rec_sup[c] == es, (last == C_RD) ? "R3" : "R7", "peer supply", rec_sup[c], es);
      if (es) chk(rec_sd[c] == shadow[a], "R3", "supplied word", rec_sd[c], shadow[a]);
    end
    if (w) begin
      if (oth) ms[o][ix] = S_I;
      ms[c][ix] = S_M;
      shadow[a] = d;
    end else if (!hit) begin
      ms[c][ix] = oth ? S_S : S_E;
      if (oth) ms[o][ix] = S_S;
    end
    mt[c][ix] = tg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "R11", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r0, r1;
    req_valid = '0; req_write = '0; resp_ready = 2'b11;
    for (int c = 0; c < 2; c++) begin
      req_addr[c] = '0; req_wdata[c] = '0; rec_n[c] = 0;
      rec_c0[c] = '0; rec_c1[c] = '0; rec_sup[c] = 0; rec_sd[c] = '0;
      for (int i = 0; i < 4; i++) begin ms[c][i] = S_I; mt[c][i] = '0; end
    end
    for (int i = 0; i < 256; i++) shadow[i] = 16'(i * 3 + 256);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 2'b11 && resp_valid == 2'b00 && bus_req == 2'b00, "R1", "reset outputs",
        {req_ready, resp_valid, bus_req}, {2'b11, 2'b00, 2'b00});

    // Sweep: every index, three tags, full sharing/ownership pattern
    for (int k = 0; k < 12; k++) begin
      logic [7:0] a = 8'((k % 4) | ((k / 4) << 2));
      do_op(0, 0, a, 0, 0);
      do_op(1, 0, a, 0, 0);
      do_op(0, 1, a, 16'(k * 16 + 1), 0);
      do_op(1, 0, a, 0, 0);
      do_op(1, 1, a, 16'(k * 16 + 2), 0);
      do_op(0, 1, a, 16'(k * 16 + 3), 0);
      do_op(0, 0, a, 0, 0);
      do_op(1, 1, a, 16'(k * 16 + 4), 0);
    end

    // R11: held response
    do_op(0, 0, 8'h05, 0, 1);

    // Arithmetic mixed sequence
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a = 8'(((i * 5) % 4) | ((((i * 7) / 3) % 3) << 2));
      do_op(((i / 3) + i) % 2, (i % 3) == 1, a, 16'(i * 257 + 3), 0);
    end

    // R9: local write hit on Exclusive races a snooped read to the same line
    do_op(1, 0, 8'h40, 0, 0);
    do_op(1, 0, 8'h40, 0, 0);
    r0 = shadow[8'h40];
    fork
      raw_op(0, 0, 8'h40, 0, 0, r1);
      raw_op(1, 1, 8'h40, 16'hBEEF, 0, r0);
    join
    chk(r1 == shadow[8'h40], "R9", "racing read sees old word", r1, shadow[8'h40]);
    shadow[8'h40] = 16'hBEEF;
    raw_op(0, 0, 8'h40, 0, 0, r0);
    chk(r0 == 16'hBEEF, "R9", "read after stalled write", r0, 16'hBEEF);
    raw_op(1, 0, 8'h40, 0, 0, r1);
    chk(r1 == 16'hBEEF, "R10", "writer reads own word", r1, 16'hBEEF);
    ms[0][0] = S_S; ms[1][0] = S_S; mt[0][0] = 6'h10; mt[1][0] = 6'h10;
    do_op(0, 1, 8'h40, 16'h1234, 0);
    do_op(1, 0, 8'h40, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule